// File: doc/BRIEF.md
# Staggered Block Overlap-Add Combiner

This block is the last stage of a frequency-spreading filter-bank multicarrier transmitter. Upstream, an inverse transform produces blocks of K·Nc complex samples, one after another on a valid/ready stream. Block m belongs to output time m·Nc/2 onward, so each block overlaps the previous ones. The combiner adds each block onto the partial sums left by earlier blocks, which gives y[n] = Σ_m x_m[n − m·Nc/2]. Once a block's contribution is in, the oldest Nc/2 output samples can receive nothing further. They leave on the output stream as finished time-domain samples.

The partial sums live in a single delay line of (2K−1)·Nc/2 complex entries, which is (2K−1)·Nc 16-bit words. Each accepted sample reads one entry and writes one entry, so no second read port is needed. A controller steps through a periodic select pattern over every block. In the first Nc/2 positions the sum is emitted and a zero is pushed into the line. In the other positions the sum is pushed back to wait for the next block. After reset, a flush phase shifts zeros through the whole line before any input is accepted. Components are Q5.11, 16 bits each, and every addition saturates.

Top module: `fbola_top`

## Requirements
- R1: While rst_n is low, in_ready and out_valid are both 0.
- R2: After rst_n rises, in_ready stays 0 for exactly (2K−1)·Nc/2 + 2 clock cycles and then goes to 1. During that time out_valid stays 0 and input samples are ignored. They leave no trace in later outputs.
- R3: Accepted samples are counted in blocks of K·Nc, with position i running 0 to K·Nc−1 inside the block. The sample at position i < Nc/2 of block m produces one output sample equal to y[m·Nc/2 + i]. Real and imaginary parts are computed separately.
- R4: Samples at positions i ≥ Nc/2 produce no output. For them, in_ready is 1 whatever out_ready is.
- R5: Each addition is clamped to the range −32768 to 32767 per component. Contributions are applied in block order, so each partial sum is clamped before the next block is added.
- R6: While in_valid is 0, out_valid is 0 and the position counter does not advance.
- R7: At positions i < Nc/2, in_ready follows out_ready and out_valid follows in_valid. A sample that is not taken by the output is not consumed.
- R8: With in_valid and out_ready both held at 1 after the flush, in_ready is 1 on every cycle. Input and output then stream without stalls.
- R9: The first block after the flush is added to zeros, so its first Nc/2 outputs equal its input samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with in_valid |
| in_re | input | 16 | Input real part, Q5.11 |
| in_im | input | 16 | Input imaginary part, Q5.11 |
| out_valid | output | 1 | Finished output sample present |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_re | output | 16 | Output real part, Q5.11 |
| out_im | output | 16 | Output imaginary part, Q5.11 |

## Verification
The bench builds the combiner with K = 2 and Nc = 8. That gives 16-sample blocks, a hop of 4 and a 12-entry delay line. Every output position then collects four overlapping contributions, and forty blocks wrap the select pattern many times. This small size makes the whole flush, the boundary between emit and store positions, and saturation in both directions reachable in a short run. A behavioural model accumulates sums per absolute output position and is checked each cycle. Traffic varies from full-rate streaming to input gaps, output backpressure and near-full-scale data.

// File: rtl/fbola_pkg.sv
package fbola_pkg;
  localparam int SW = 16;

  typedef logic signed [SW-1:0] samp_t;

  typedef struct packed {
    samp_t re;
    samp_t im;
  } cplx_t;

  typedef enum logic {ST_FLUSH = 1'b0, ST_OAA = 1'b1} fbola_st_e;

  function automatic samp_t sat_add(samp_t a, samp_t b);
    logic signed [SW:0] s;
    s = {a[SW-1], a} + {b[SW-1], b};
    if (s[SW] != s[SW-1])
      sat_add = s[SW] ? {1'b1, {(SW-1){1'b0}}} : {1'b0, {(SW-1){1'b1}}};
    else
      sat_add = s[SW-1:0];
  endfunction
endpackage

// File: rtl/fbola_ctrl.sv
module fbola_ctrl
  import fbola_pkg::*;
#(
  parameter int K  = 4,
  parameter int NC = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  output logic                       flush_o,
  output logic                       emit_o,
  output logic [$clog2(K*NC)-1:0]    idx_o
);
  localparam int L  = K * NC;
  localparam int H  = NC / 2;
  localparam int D  = L - H;
  localparam int IW = $clog2(L);
  localparam int FW = $clog2(D);

  fbola_st_e        state_q, state_d;
  logic [FW-1:0]    fcnt_q, fcnt_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic             fcnt_en, idx_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    fcnt_d  = fcnt_q;
    idx_d   = idx_q;
    fcnt_en = 1'b0;
    idx_en  = 1'b0;
    case (state_q)
      ST_FLUSH: begin
        fcnt_en = 1'b1;
        if (fcnt_q == FW'(D - 1)) begin
          fcnt_d  = '0;
          state_d = ST_OAA;
        end else begin
          fcnt_d = fcnt_q + 1'b1;
        end
      end
      default: begin
        if (accept) begin
          idx_en = 1'b1;
          idx_d  = (idx_q == IW'(L - 1)) ? '0 : idx_q + 1'b1;
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FLUSH;
      fcnt_q  <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fcnt_en) fcnt_q <= fcnt_d;
      if (idx_en)  idx_q  <= idx_d;
    end
  end

  assign flush_o = (state_q == ST_FLUSH);
  assign emit_o  = (idx_q < IW'(H));
  assign idx_o   = idx_q;
endmodule

// File: rtl/fbola_delay_line.sv
module fbola_delay_line
  import fbola_pkg::*;
#(
  parameter int DEPTH = 1792
) (
  input  logic  clk,
  input  logic  shift_en,
  input  cplx_t din,
  output cplx_t dout
);
  cplx_t line [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_stage
    if (j == DEPTH - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (shift_en) line[j] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (shift_en) line[j] <= line[j+1];
      end
    end
  end

  assign dout = line[0];
endmodule

// File: rtl/fbola_cadd.sv
module fbola_cadd
  import fbola_pkg::*;
(
  input  cplx_t a,
  input  cplx_t b,
  output cplx_t y
);
  always_comb begin
    y.re = sat_add(a.re, b.re);
    y.im = sat_add(a.im, b.im);
  end
endmodule

// File: rtl/fbola_top.sv
module fbola_top
  import fbola_pkg::*;
#(
  parameter int K  = 4,
  parameter int NC = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [15:0]   in_re,
  input  logic signed [15:0]   in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [15:0]   out_re,
  output logic signed [15:0]   out_im
);
  localparam int L  = K * NC;
  localparam int H  = NC / 2;
  localparam int D  = L - H;
  localparam int IW = $clog2(L);

  logic [1:0]    rsync_q;
  logic          rst_i;
  logic          flush, emit, accept;
  logic [IW-1:0] idx;
  cplx_t         x_in, head, sum, tail;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  fbola_ctrl #(.K(K), .NC(NC)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i),
    .accept  (accept),
    .flush_o (flush),
    .emit_o  (emit),
    .idx_o   (idx)
  );

  assign x_in.re = in_re;
  assign x_in.im = in_im;

  fbola_cadd u_add (
    .a (head),
    .b (x_in),
    .y (sum)
  );

  assign in_ready  = !flush && (!emit || out_ready);
  assign accept    = in_valid && in_ready;
  assign out_valid = in_valid && !flush && emit;
  assign out_re    = sum.re;
  assign out_im    = sum.im;
  assign tail      = (flush || emit) ? '0 : sum;

  fbola_delay_line #(.DEPTH(D)) u_line (
    .clk      (clk),
    .shift_en (flush || accept),
    .din      (tail),
    .dout     (head)
  );
endmodule

// File: rtl/fbola_chk.sv
module fbola_chk #(
  parameter int K  = 4,
  parameter int NC = 512
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    flush,
  input logic                    emit,
  input logic [$clog2(K*NC)-1:0] idx
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!in_ready && !out_valid); // R1
    end
  end

  AST_FLUSH_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!in_ready && !out_valid)); // R2

  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && in_ready == out_ready)); // R7

  AST_TAIL_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !emit) |-> (in_ready && !out_valid)); // R4

  AST_HOLD_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(in_valid && in_ready)) |=> $stable(idx)); // R6

  AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && in_valid && out_ready) |-> in_ready); // R8
endmodule

bind fbola_top fbola_chk #(.K(K), .NC(NC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .flush     (flush),
  .emit      (emit),
  .idx       (idx)
);

// File: tb/tb_fbola_top.sv
module tb_fbola_top;
  localparam int CLK_P = 10;
  localparam int K  = 2;
  localparam int NC = 8;
  localparam int L  = K * NC;
  localparam int H  = NC / 2;
  localparam int D  = L - H;
  localparam int NB = 40;
  localparam int NP = NB * H + L;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, out_valid, out_ready;
  logic signed [15:0] in_re, in_im, out_re, out_im;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int xre [NB][L];
  int xim [NB][L];
  int yre [NP];
  int yim [NP];
  int mb, mi, k, pos;
  bit oaa, e_emit, e_ready, e_ov;
  string tag;

  always #(CLK_P/2) clk = ~clk;

  fbola_top #(.K(K), .NC(NC)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im)
  );

  function automatic int sat16(int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog expired actual=0 expected=1");
      summary();
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < L; i++) begin
        if (b >= 30) begin
          xre[b][i] = ($urandom_range(0, 1) != 0 ? 1 : -1) * (28000 + int'($urandom_range(0, 4000)));
          xim[b][i] = ($urandom_range(0, 1) != 0 ? 1 : -1) * (28000 + int'($urandom_range(0, 4000)));
        end else begin
          xre[b][i] = int'($urandom_range(0, 8191)) - 4096;
          xim[b][i] = int'($urandom_range(0, 8191)) - 4096;
        end
      end
    end
    for (int p = 0; p < NP; p++) begin
      yre[p] = 0;
      yim[p] = 0;
    end

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_re = '0; in_im = '0;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!in_ready, "R1 in_ready", int'(in_ready), 0);
      chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
    end

    // release reset and drive junk that must be ignored during the flush
    @(negedge clk);
    rst_n = 1'b1; k = 0; mb = 0; mi = 0;
    in_valid = 1'b1; in_re = 16'sh7fff; in_im = -16'sd32768;

    while (mb < NB) begin
      @(negedge clk);
      k++;
      oaa = (k >= D + 2);
      if (oaa) begin
        in_valid  = (mb >= 10 && mb < 20) ? ($urandom_range(0, 2) != 0) : 1'b1;
        out_ready = (mb >= 20 && mb < 30) ? ($urandom_range(0, 2) != 0) : 1'b1;
        in_re = 16'(xre[mb][mi]);
        in_im = 16'(xim[mb][mi]);
      end
      #1;
      e_emit  = (mi < H);
      e_ready = oaa && (!e_emit || out_ready);
      e_ov    = in_valid && oaa && e_emit;

      if (!oaa)                       tag = "R2 in_ready";
      else if (!e_emit)               tag = "R4 in_ready";
      else if (in_valid && out_ready) tag = "R8 in_ready";
      else                            tag = "R7 in_ready";
      chk(in_ready == e_ready, tag, int'(in_ready), int'(e_ready));

      if (!in_valid)    tag = "R6 out_valid";
      else if (!oaa)    tag = "R2 out_valid";
      else              tag = "R3 out_valid";
      chk(out_valid == e_ov, tag, int'(out_valid), int'(e_ov));

      if (in_valid && e_ready) begin
        pos = mb * H + mi;
        yre[pos] = sat16(yre[pos] + xre[mb][mi]);
        yim[pos] = sat16(yim[pos] + xim[mb][mi]);
        if (e_ov) begin
          if (mb == 0)       tag = "R9 data";
          else if (mb >= 30) tag = "R5 data";
          else               tag = "R3 data";
          chk(int'(out_re) == yre[pos], {tag, " re"}, int'(out_re), yre[pos]);
          chk(int'(out_im) == yim[pos], {tag, " im"}, int'(out_im), yim[pos]);
        end
        mi++;
        if (mi == L) begin
          mi = 0;
          mb++;
        end
      end
    end

    // idle: nothing is produced without valid input
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (5) begin
      @(negedge clk); #1;
      chk(!out_valid, "R6 idle out_valid", int'(out_valid), 0);
      chk(in_ready, "R7 idle in_ready", int'(in_ready), 1);
    end

    done = 1'b1;
    summary();
  end
endmodule